// File: doc/BRIEF.md
# Table-Driven Hub Slot Arbiter

This block decides which core may use the shared hub memory in each clock cycle. A slot pointer steps once per cycle through an ownership table that has more entries than there are cores. Each entry names the core that owns that time slot. A core with a heavy data stream can own several entries and so get a larger, fixed share of the hub. A slow peripheral core can own a single entry per rotation. Every core sees the same access pattern in each rotation, so its access timing is known in advance.

The grant goes to the owner of the current slot only when that core asserts its request. If the owner is idle, or the entry names a core number that does not exist, nobody uses the slot. Table writes go into a staging copy, and that copy becomes the live table at the rotation boundary. The live table therefore never changes partway through a rotation.

Top module: `hub_slot_arbiter`

## Requirements
- R1: While reset is held, and until the first slot advance after it, slot_o is 0 and live entry i names core i modulo NUM_CORES. With the defaults (16 cores, 32 slots), slots i and i+16 both belong to core i.
- R2: slot_o advances by one on every clock edge after reset release and wraps from SLOTS-1 to 0.
- R3: grant_o has bit c set only when the current live entry names core c and req_i[c] is 1. Otherwise grant_o is all zeros.
- R4: At most one bit of grant_o is set in any cycle.
- R5: A core that owns k entries of the live table and requests continuously receives exactly k grants per rotation.
- R6: A write (wr_en_i=1, entry wr_slot_i receives core number wr_core_i) does not change any grant during the current rotation. It applies from slot 0 of the next rotation.
- R7: An entry whose value is NUM_CORES or larger (16 to 31 with the defaults) never produces a grant, whatever the requests are.
- R8: A write issued in the cycle in which slot_o equals SLOTS-1 is already in force when slot 0 of the following rotation begins.
- R9: Requests from cores that do not own the current slot are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Table write strobe |
| wr_slot_i | input | IDX_W | Entry to write |
| wr_core_i | input | ENTRY_W | Core number stored in that entry |
| req_i | input | NUM_CORES | Per-core hub request |
| grant_o | output | NUM_CORES | One-hot grant for the current slot, all zero when the slot is unused |
| slot_o | output | IDX_W | Current slot index |

## Verification
The assertions check four properties on every cycle: the slot pointer steps by one and wraps, the grant has at most one bit set, no bit is granted without its request, and the live table stays fixed except at the wrap. They also check that an entry naming a nonexistent core yields no grant. Only the bench scenarios can show the timing of writes relative to the rotation: a write lands at the start of the next rotation, including a write made in the final slot. The same holds for the per-rotation grant counts that give the unequal bandwidth shares and for the default mapping after reset. The bench compares grant_o and slot_o against a cycle model that keeps its own staging and live tables.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;
  // Core number that owns a slot in the equal mapping used at reset.
  function automatic int unsigned equal_owner(int unsigned slot, int unsigned cores);
    return slot % cores;
  endfunction
endpackage

// File: rtl/hub_rst_sync.sv
module hub_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/hub_slot_counter.sv
module hub_slot_counter #(
  parameter int SLOTS = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] slot_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] slot_q, slot_d;

  always_comb begin
    if (slot_q == LAST) slot_d = '0;
    else                slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  assign slot_o = slot_q;
  assign last_o = (slot_q == LAST);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == LAST) |=> (slot_q == '0));
endmodule

// File: rtl/hub_slot_table.sv
module hub_slot_table
  import hub_arb_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int SLOTS = 32,
  parameter int ENTRY_W = 5,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_slot_i,
  input  logic [ENTRY_W-1:0] wr_core_i,
  input  logic               rot_end_i,
  input  logic [IDX_W-1:0]   rd_slot_i,
  output logic [ENTRY_W-1:0] owner_o
);
  logic [SLOTS-1:0][ENTRY_W-1:0] stage_q, stage_d;
  logic [SLOTS-1:0][ENTRY_W-1:0] live_q, live_d;

  // Staging copy takes writes at once; live copy reloads only at wrap.
  always_comb begin
    stage_d = stage_q;
    if (wr_en_i) stage_d[wr_slot_i] = wr_core_i;
    live_d = live_q;
    if (rot_end_i) live_d = stage_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) begin
        stage_q[i] <= ENTRY_W'(equal_owner(i, NUM_CORES));
        live_q[i]  <= ENTRY_W'(equal_owner(i, NUM_CORES));
      end
    end else begin
      stage_q <= stage_d;
      live_q  <= live_d;
    end
  end

  assign owner_o = live_q[rd_slot_i];

  // R6: the live table holds still for the whole rotation
  a_r6_live_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rot_end_i |=> $stable(live_q));
endmodule

// File: rtl/hub_grant_decode.sv
module hub_grant_decode #(
  parameter int NUM_CORES = 16,
  parameter int ENTRY_W = 5
) (
  input  logic [ENTRY_W-1:0]   owner_i,
  input  logic [NUM_CORES-1:0] req_i,
  output logic [NUM_CORES-1:0] grant_o
);
  logic owner_ok;
  assign owner_ok = (int'(owner_i) < NUM_CORES);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign grant_o[c] = owner_ok && (owner_i == ENTRY_W'(c)) && req_i[c];
  end

  always_comb begin
    a_r4_single: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter #(
  parameter int NUM_CORES = 16,
  parameter int SLOTS = 32,
  parameter int ENTRY_W = 5,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_slot_i,
  input  logic [ENTRY_W-1:0]   wr_core_i,
  input  logic [NUM_CORES-1:0] req_i,
  output logic [NUM_CORES-1:0] grant_o,
  output logic [IDX_W-1:0]     slot_o
);
  logic               rst_n_int;
  logic               rot_end;
  logic [IDX_W-1:0]   slot;
  logic [ENTRY_W-1:0] owner;

  hub_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_int)
  );

  hub_slot_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .slot_o(slot),
    .last_o(rot_end)
  );

  hub_slot_table #(
    .NUM_CORES(NUM_CORES), .SLOTS(SLOTS), .ENTRY_W(ENTRY_W)
  ) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .wr_en_i  (wr_en_i),
    .wr_slot_i(wr_slot_i),
    .wr_core_i(wr_core_i),
    .rot_end_i(rot_end),
    .rd_slot_i(slot),
    .owner_o  (owner)
  );

  hub_grant_decode #(.NUM_CORES(NUM_CORES), .ENTRY_W(ENTRY_W)) u_dec (
    .owner_i(owner),
    .req_i  (req_i),
    .grant_o(grant_o)
  );

  assign slot_o = slot;

  // R3 / R9: no grant without the matching request
  a_r3_needs_req: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (grant_o & ~req_i) == '0);
  // R7: entries beyond the core count stay empty
  a_r7_bad_owner_idle: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (int'(owner) >= NUM_CORES) |-> (grant_o == '0));
endmodule

// File: tb/hub_slot_arbiter_test.sv
module hub_slot_arbiter_test;
  localparam int NC = 16;
  localparam int NS = 32;
  localparam int EW = 5;
  localparam int IW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we;
  logic [IW-1:0] wa;
  logic [EW-1:0] wd;
  logic [NC-1:0] req;
  logic [NC-1:0] grant;
  logic [IW-1:0] slot;

  int checks = 0;
  int errors = 0;
  int m_stage[NS];
  int m_live[NS];
  int m_idx;
  int gcount[NC];

  always #10 clk = ~clk;

  hub_slot_arbiter #(.NUM_CORES(NC), .SLOTS(NS), .ENTRY_W(EW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_slot_i(wa),
    .wr_core_i(wd), .req_i(req), .grant_o(grant), .slot_o(slot)
  );

  function automatic logic [NC-1:0] exp_grant(int owner, logic [NC-1:0] r);
    logic [NC-1:0] e = '0;
    if (owner < NC && r[owner]) e[owner] = 1'b1;
    return e;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at falling edge, compare, then advance the model.
  task automatic cycle(logic [NC-1:0] r, bit w, int a, int d, string tag);
    logic [NC-1:0] e;
    @(negedge clk);
    req = r; we = w; wa = IW'(a); wd = EW'(d);
    #1;
    e = exp_grant(m_live[m_idx], r);
    check(slot == IW'(m_idx), "R2 slot index", int'(slot), m_idx);
    check(grant == e, tag, int'(grant), int'(e));
    check($countones(grant) <= 1, "R4 single grant", int'(grant), int'(e));
    for (int c = 0; c < NC; c++) if (grant[c]) gcount[c]++;
    if (w) m_stage[a] = d;
    if (m_idx == NS - 1) m_live = m_stage;
    m_idx = (m_idx + 1) % NS;
  endtask

  task automatic align_to_zero();
    while (m_idx != 0) cycle('1, 1'b0, 0, 0, "R3 grant");
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; we = 1'b0; wa = '0; wd = '0; req = '1;
    for (int i = 0; i < NS; i++) begin m_stage[i] = i % NC; m_live[i] = i % NC; end
    m_idx = 0;
    repeat (3) @(negedge clk);
    #1;
    check(slot == '0, "R1 reset slot", int'(slot), 0);
    check(grant == 16'h0001, "R1 reset owner", int'(grant), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1: default equal mapping over two full rotations
    for (int i = 0; i < 2 * NS; i++) cycle('1, 1'b0, 0, 0, "R1 default map");

    // R3 / R9: sparse and random requests
    for (int i = 0; i < NS; i++) cycle(NC'(1) << (i % NC), 1'b0, 0, 0, "R3 owner requests");
    for (int i = 0; i < NS; i++) cycle(~(NC'(1) << (i % NC)), 1'b0, 0, 0, "R9 others ignored");
    for (int i = 0; i < NS; i++) cycle(NC'($urandom), 1'b0, 0, 0, "R3 random req");

    // R6 / R7 / R8: writes mid-rotation and in the last slot
    align_to_zero();
    for (int i = 0; i < 10; i++) cycle('1, 1'b0, 0, 0, "R3 grant");
    cycle('1, 1'b1, 12, 3, "R6 same rotation");
    cycle('1, 1'b1, 13, 20, "R6 same rotation");
    while (m_idx != NS - 1) cycle('1, 1'b0, 0, 0, "R6 old table held");
    cycle('1, 1'b1, 0, 31, "R8 last slot write");
    for (int i = 0; i < NS; i++) cycle('1, 1'b0, 0, 0, "R7 R8 new table");

    // R5: core 2 owns every fourth slot, core 9 one slot, rest empty
    align_to_zero();
    for (int i = 0; i < NS; i++)
      cycle('1, 1'b1, i, (i % 4 == 0) ? 2 : (i == 7 ? 9 : 17 + (i % 15)), "R6 rewrite");
    for (int c = 0; c < NC; c++) gcount[c] = 0;
    for (int i = 0; i < NS; i++) cycle('1, 1'b0, 0, 0, "R5 share");
    check(gcount[2] == 8, "R5 core2 grants", gcount[2], 8);
    check(gcount[9] == 1, "R5 core9 grants", gcount[9], 1);
    check(gcount[0] == 0, "R7 empty slots", gcount[0], 0);

    // Random writes and requests
    for (int i = 0; i < 1500; i++)
      cycle(NC'($urandom), ($urandom % 8) == 0, int'($urandom % NS), int'($urandom % 32), "R6 random");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule